// File: doc/BRIEF.md
# POLYVAL Aggregated Block Hasher

This block advances a 128-bit POLYVAL accumulator over a run of 16-byte message blocks. The caller supplies a block count, the starting accumulator and a table of eight key powers (h^8 down to h^1), then streams the blocks through a valid/ready input. When the run is finished the block raises a one-cycle completion pulse and presents the new accumulator.

Blocks are handled in strides. While eight or more blocks remain, a stride holds eight blocks. Once fewer than eight remain, the remainder is split into strides of four, two and one, chosen from the bits of the remaining count. Within a stride, each block is multiplied by a key power using a three-way Karatsuba carry-less multiply, and the products are not reduced. The low, middle and high partial products are summed by XOR. The running accumulator is XORed into the first block of the stride. The single Montgomery reduction modulo x^128 + x^127 + x^126 + x^121 + 1 happens only when the stride ends. A stride of length L starts at power h^L, so its last block always meets h^1.

Top module: `pvhash_agg`

## Requirements
- R1: After reset, `done`, `busy` and `blkReady` are low and `accOut` is zero.
- R2: A start with a count of zero produces exactly one `done` pulse, accepts no block, and returns `accIn` unchanged on `accOut`.
- R3: For a count that is a multiple of eight, `accOut` equals h^n·acc + h^n·m_0 + h^(n-1)·m_1 + … + h^1·m_(n-1). Here m_0 is the first block accepted. Every product is a·b·x^-128 mod (x^128 + x^127 + x^126 + x^121 + 1), and bit i of a 128-bit value is the coefficient of x^i. Slot k of `keyPowers` (bits k·128 upward) holds h^(8-k), and h^(j+1) = h^j·h under that product.
- R4: For a count that is not a multiple of eight, `accOut` equals the same expression. The leftover blocks are taken in strides of 4, 2 and 1, and each stride starts at the key power matching its length.
- R5: Exactly `blkCount` blocks are accepted per run, and `blkReady` is never high while `busy` is low.
- R6: `done` is high for exactly one cycle per accepted start, and `busy` is low during that cycle.
- R7: A `start` pulse while `busy` is high is ignored, so the run in progress completes with its own count and result.
- R8: `accOut` changes only in the cycle in which `done` is high, and it holds that value until the next `done`.
- R9: Idle cycles on `blkValid` between blocks do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (taken only while idle) |
| blkCount | input | CNT_W | Number of blocks in the run |
| accIn | input | 128 | Starting accumulator |
| keyPowers | input | 1024 | Eight key powers; slot k holds h^(8-k) |
| blkValid | input | 1 | Message block present |
| blkData | input | 128 | Message block |
| blkReady | output | 1 | Block accepted when high with blkValid |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| accOut | output | 128 | Updated accumulator, held between runs |

## Verification
The assertions are checked on every cycle and cover the stride and counter invariants. A block is accepted only while blocks remain in the run. A stride never extends past the remaining count, and a stride length is always a power of two. `done` is a single-cycle pulse, and `accOut` holds between pulses. The field arithmetic can only be shown by the bench scenarios. These compare results against a bit-serial Montgomery model for counts 0 through 20, with and without idle gaps. The bench scenarios also show that a start issued mid-run is ignored, and they count the accepted handshakes.

// File: rtl/pvhash_pkg.sv
package pvhash_pkg;
  localparam int BLK_W  = 128;
  localparam int HALF_W = BLK_W / 2;
  localparam int GROUP  = 8;
  localparam int KIDX_W = $clog2(GROUP);
  localparam int LEN_W  = KIDX_W + 1;

  // x^128 + x^127 + x^126 + x^121 + 1
  localparam logic [2*BLK_W-1:0] FIELD_POLY =
    {127'b0, 3'b111, 4'b0, 1'b1, 120'b0, 1'b1};

  typedef struct packed {
    logic              loadAcc;
    logic              clrProd;
    logic              accumProd;
    logic              xorSum;
    logic [KIDX_W-1:0] keyIdx;
    logic              storeRed;
    logic              latchOut;
  } strobe_t;

  function automatic logic [BLK_W-1:0] clmul(input logic [HALF_W-1:0] a,
                                             input logic [HALF_W-1:0] b);
    logic [BLK_W-1:0] r;
    r = '0;
    for (int i = 0; i < HALF_W; i++)
      if (b[i]) r = r ^ ({{HALF_W{1'b0}}, a} << i);
    return r;
  endfunction

  // Clears the low half by adding multiples of the field polynomial, then
  // keeps the high half: p * x^-128 mod g.
  function automatic logic [BLK_W-1:0] montReduce(input logic [2*BLK_W-1:0] p);
    logic [2*BLK_W-1:0] t;
    t = p;
    for (int i = 0; i < BLK_W; i++)
      if (t[i]) t = t ^ (FIELD_POLY << i);
    return t[2*BLK_W-1:BLK_W];
  endfunction
endpackage

// File: rtl/pvhash_datapath.sv
module pvhash_datapath
  import pvhash_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [BLK_W-1:0]       accIn,
  input  logic [GROUP*BLK_W-1:0] keyPowers,
  input  logic [BLK_W-1:0]       blkData,
  output logic [BLK_W-1:0]       accOut
);
  logic [BLK_W-1:0]   sumQ, loQ, miQ, hiQ, accOutQ;
  logic [BLK_W-1:0]   opA, opB, loP, miP, hiP, reduced;
  logic [2*BLK_W-1:0] combined;

  always_comb begin
    opA = blkData ^ (stb.xorSum ? sumQ : '0);
    opB = keyPowers[int'(stb.keyIdx)*BLK_W +: BLK_W];
    loP = clmul(opA[HALF_W-1:0], opB[HALF_W-1:0]);
    hiP = clmul(opA[BLK_W-1:HALF_W], opB[BLK_W-1:HALF_W]);
    miP = clmul(opA[HALF_W-1:0] ^ opA[BLK_W-1:HALF_W],
                opB[HALF_W-1:0] ^ opB[BLK_W-1:HALF_W]);
    combined = {hiQ, {BLK_W{1'b0}}}
             ^ {{HALF_W{1'b0}}, miQ ^ hiQ ^ loQ, {HALF_W{1'b0}}}
             ^ {{BLK_W{1'b0}}, loQ};
    reduced = montReduce(combined);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ    <= '0;
      loQ     <= '0;
      miQ     <= '0;
      hiQ     <= '0;
      accOutQ <= '0;
    end else begin
      if (stb.loadAcc)  sumQ <= accIn;
      if (stb.storeRed) sumQ <= reduced;
      if (stb.clrProd) begin
        loQ <= '0;
        miQ <= '0;
        hiQ <= '0;
      end else if (stb.accumProd) begin
        loQ <= loQ ^ loP;
        miQ <= miQ ^ miP;
        hiQ <= hiQ ^ hiP;
      end
      if (stb.latchOut) accOutQ <= sumQ;
    end
  end

  assign accOut = accOutQ;
endmodule

// File: rtl/pvhash_ctrl.sv
module pvhash_ctrl
  import pvhash_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] blkCount,
  input  logic             blkValid,
  output logic             blkReady,
  output logic             busy,
  output logic             done,
  output strobe_t          stb
);
  typedef enum logic [1:0] {S_IDLE, S_PICK, S_BLK, S_RED} state_t;

  state_t            stateQ;
  logic [CNT_W-1:0]  remQ;
  logic [KIDX_W-1:0] posQ;
  logic [LEN_W-1:0]  lenQ, pickLen, keyIdxW;
  logic              doneQ, lastInStride;

  always_comb begin
    pickLen = '0;
    if (remQ >= CNT_W'(GROUP)) pickLen = LEN_W'(GROUP);
    else
      for (int b = 0; b < KIDX_W; b++)
        if (remQ[b]) pickLen = LEN_W'(1) << b;
    keyIdxW      = LEN_W'(GROUP) - lenQ + LEN_W'(posQ);
    lastInStride = (LEN_W'(posQ) + LEN_W'(1)) == lenQ;
  end

  always_comb begin
    stb = '0;
    unique case (stateQ)
      S_IDLE: stb.loadAcc = start;
      S_PICK: begin
        stb.latchOut = (remQ == '0);
        stb.clrProd  = (remQ != '0);
      end
      S_BLK: begin
        stb.accumProd = blkValid;
        stb.xorSum    = (posQ == '0);
        stb.keyIdx    = keyIdxW[KIDX_W-1:0];
      end
      S_RED: stb.storeRed = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      remQ   <= '0;
      posQ   <= '0;
      lenQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        S_IDLE: if (start) begin
          remQ   <= blkCount;
          stateQ <= S_PICK;
        end
        S_PICK: if (remQ == '0) begin
          doneQ  <= 1'b1;
          stateQ <= S_IDLE;
        end else begin
          lenQ   <= pickLen;
          posQ   <= '0;
          stateQ <= S_BLK;
        end
        S_BLK: if (blkValid) begin
          remQ <= remQ - CNT_W'(1);
          posQ <= posQ + KIDX_W'(1);
          if (lastInStride) stateQ <= S_RED;
        end
        S_RED: stateQ <= S_PICK;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign blkReady = (stateQ == S_BLK);
  assign busy     = (stateQ != S_IDLE);
  assign done     = doneQ;

  AST_BLK_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BLK) |-> (remQ != '0)); // R5
  AST_STRIDE_FITS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BLK) |-> (remQ >= CNT_W'(lenQ - LEN_W'(posQ)))); // R4
  AST_STRIDE_POW2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BLK) |-> ($countones(lenQ) == 1)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R6
endmodule

// File: rtl/pvhash_agg.sv
module pvhash_agg
  import pvhash_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [CNT_W-1:0]       blkCount,
  input  logic [BLK_W-1:0]       accIn,
  input  logic [GROUP*BLK_W-1:0] keyPowers,
  input  logic                   blkValid,
  input  logic [BLK_W-1:0]       blkData,
  output logic                   blkReady,
  output logic                   busy,
  output logic                   done,
  output logic [BLK_W-1:0]       accOut
);
  strobe_t stb;

  pvhash_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .blkCount(blkCount),
    .blkValid(blkValid), .blkReady(blkReady), .busy(busy), .done(done),
    .stb(stb)
  );

  pvhash_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .accIn(accIn),
    .keyPowers(keyPowers), .blkData(blkData), .accOut(accOut)
  );

  AST_ACCOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(accOut)); // R8
endmodule

// File: tb/pvhash_agg_tb_top.sv
`timescale 1ns/1ps
module pvhash_agg_tb_top;
  localparam int CNT_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  blkCount = '0;
  logic [127:0]      accIn = '0;
  logic [1023:0]     keyPowers = '0;
  logic              blkValid = 1'b0;
  logic [127:0]      blkData = '0;
  logic              blkReady, busy, done;
  logic [127:0]      accOut;

  int errors = 0;
  int checks = 0;
  int issued = 0;
  int completed = 0;
  int hsCount = 0;
  logic holdBad = 1'b0;
  logic prevDone = 1'b0;
  logic [127:0] lastOut = '0;
  logic [127:0] pw [1:8];

  typedef struct {
    logic [127:0] exp;
    int           n;
    string        tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  pvhash_agg #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .blkCount(blkCount),
    .accIn(accIn), .keyPowers(keyPowers), .blkValid(blkValid),
    .blkData(blkData), .blkReady(blkReady), .busy(busy), .done(done),
    .accOut(accOut)
  );

  // Bit-serial Montgomery product: a*b*x^-128 mod g
  function automatic logic [127:0] gfDot(input logic [127:0] a, input logic [127:0] b);
    logic [128:0] r;
    logic [128:0] g;
    g = {1'b1, 2'b11, 4'b0, 1'b1, 120'b0, 1'b1};
    r = '0;
    for (int i = 0; i < 128; i++) begin
      if (b[i]) r = r ^ {1'b0, a};
      if (r[0]) r = r ^ g;
      r = r >> 1;
    end
    return r[127:0];
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (blkValid && blkReady) hsCount++;
      if (blkReady && !busy) holdBad = 1'b1;
      if (done) begin
        item_t it;
        check(!prevDone, "R6 done width", 128'(prevDone), 128'(0));
        check(!busy, "R6 busy at done", 128'(busy), 128'(0));
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected done", accOut, '0);
        end else begin
          it = expQ.pop_front();
          check(accOut == it.exp, $sformatf("%s n=%0d result", it.tag, it.n),
                accOut, it.exp);
          check(hsCount == it.n, $sformatf("R5 n=%0d accepted", it.n),
                128'(hsCount), 128'(it.n));
        end
        check(!holdBad, "R8 accOut hold / R5 ready while idle",
              128'(holdBad), 128'(0));
        holdBad  = 1'b0;
        hsCount  = 0;
        lastOut  = accOut;
        completed++;
      end else if (accOut != lastOut) begin
        holdBad = 1'b1;
      end
      prevDone = done;
    end
  end

  task automatic runOp(input int n, input logic [127:0] acc, input int gap,
                       input int interrupt, input string tag);
    logic [127:0] blks [0:31];
    item_t it;
    logic [127:0] e;
    e = acc;
    for (int i = 0; i < n; i++) begin
      blks[i] = rnd128();
      e = gfDot(e ^ blks[i], pw[1]);
    end
    it.exp = e;
    it.n = n;
    it.tag = tag;
    expQ.push_back(it);
    issued++;
    @(negedge clk);
    start = 1'b1;
    blkCount = CNT_W'(n);
    accIn = acc;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (interrupt != 0 && i == interrupt) begin
        start = 1'b1;
        blkCount = CNT_W'(3);
        accIn = ~acc;
        @(negedge clk);
        start = 1'b0;
      end
      blkValid = 1'b1;
      blkData = blks[i];
      while (!blkReady) @(negedge clk);
      @(negedge clk);
      blkValid = 1'b0;
      blkData = rnd128();
      repeat (gap) @(negedge clk);
    end
    while (completed < issued) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] h;
    h = 128'h25629347_589242761_d31f826b_a4b757b ^ 128'h1;
    pw[1] = h;
    for (int k = 2; k <= 8; k++) pw[k] = gfDot(pw[k-1], h);
    for (int k = 0; k < 8; k++) keyPowers[k*128 +: 128] = pw[8-k];

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!done, "R1 done", 128'(done), 0);
    check(!busy, "R1 busy", 128'(busy), 0);
    check(!blkReady, "R1 blkReady", 128'(blkReady), 0);
    check(accOut == '0, "R1 accOut", accOut, 0);

    runOp(0, rnd128(), 0, 0, "R2");
    for (int n = 1; n <= 20; n++)
      runOp(n, rnd128(), 0, 0, (n % 8 == 0) ? "R3" : "R4");
    for (int n = 1; n <= 20; n += 3)
      runOp(n, rnd128(), 1 + (n % 3), 0, "R9");
    runOp(16, rnd128(), 2, 0, "R9 R3");
    runOp(11, rnd128(), 1, 5, "R7");
    runOp(0, rnd128(), 0, 0, "R2");

    repeat (5) @(negedge clk);
    check(completed == issued, "R6 pulse count", 128'(completed), 128'(issued));
    summary();
    $finish;
  end
endmodule